// File: doc/BRIEF.md
# Dual-Width FIFO Access Port

This block joins a 32-bit register bus to the byte-oriented transmit and receive queues of a serial controller, and it holds both queues. Software reaches the queues through two address windows. The byte window moves a single byte per access. The word window moves four bytes per access, packed little-endian. A width-select input picks which of the two windows is live. The same input sets how the queue status flags are judged: in four-byte terms or in one-byte terms.

On the far side, a serial engine pulls transmit bytes one at a time from a peek-and-pop port. It delivers received bytes one at a time through a push port. The receive queue holds twice as many bytes as the transmit queue. This lets software fill the transmit queue completely without reading anything back. Misuse of either window is dropped cleanly, and it is recorded in sticky overflow and underflow flags. A flush input clears both queues and both flags.

Top module: `fwp_top`

## Requirements
- R1: With `wide` low, a write to the byte window (`bus_addr` = `BYTE_OFS`, default 0) queues `bus_wdata[7:0]` for transmission. The engine sees queued bytes at `eng_tx_byte` in write order, and each `eng_pop` advances to the next byte.
- R2: With `wide` high, a write to the word window (`bus_addr` = `WORD_OFS`, default 4) queues four bytes. Bits [7:0] go out first, then [15:8], [23:16] and [31:24].
- R3: With `wide` low, a read from the byte window returns the oldest received byte in `bus_rdata[7:0]`, with bits [31:8] zero. The value appears one clock after the read strobe.
- R4: With `wide` high, a read from the word window returns the four oldest received bytes. The oldest byte is in bits [7:0] and the newest of the four is in bits [31:24]. The value appears one clock after the strobe.
- R5: The receive queue holds exactly twice `TX_DEPTH` bytes (16 by default). `eng_rx_ready` drops once it is full, and any further engine pushes are discarded.
- R6: `tx_full` is high, and `tx_avail` is low, when the free transmit space is less than one access unit. The unit is 4 bytes with `wide` high and 1 byte with `wide` low.
- R7: `rx_empty` is high, and `rx_avail` is low, when the stored receive bytes are fewer than one access unit (4 with `wide` high, 1 with `wide` low).
- R8: A write to the live window while `tx_full` is high is dropped whole. It sets the sticky `ovf` output, which stays high until a flush.
- R9: A read from the live window while `rx_empty` is high returns zero and leaves the receive queue unchanged. It sets the sticky `udf` output, which stays high until a flush.
- R10: An access to the window that does not match `wide` changes neither queue and sets neither sticky flag. A read of that kind returns zero.
- R11: A one-cycle `flush` empties both queues and clears `ovf` and `udf` by the next clock.
- R12: After reset, both queues are empty, `ovf`, `udf` and `bus_rdata` are zero, `eng_tx_valid` is low and `eng_rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty both queues and clear sticky flags |
| wide | input | 1 | High: word window live, four-byte flags; low: byte window live |
| bus_addr | input | ADDR_W (4) | Window address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| eng_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_byte | output | 8 | Transmit head byte |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_ready | output | 1 | Receive queue has room |
| tx_full | output | 1 | Less than one unit of transmit space |
| tx_avail | output | 1 | At least one unit of transmit space |
| rx_empty | output | 1 | Less than one unit of received data |
| rx_avail | output | 1 | At least one unit of received data |
| ovf | output | 1 | Sticky: a write was dropped |
| udf | output | 1 | Sticky: a read found too little data |

## Verification
Queue levels change on the clock edge that samples a strobe. The four status flags are decoded combinationally from those levels and from `wide`, so they are valid right after that edge. A change of `wide` alone is visible within the same cycle. `bus_rdata` and the sticky flags are registered and are due one edge after the strobe, while `eng_tx_byte` shows the head before the pop edge. The bench drives every input at the falling edge and samples at the next falling edge, with a 1 ns settle after a change of `wide` only.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned CNT_W      = 3;  // byte count per access, 0..4

    typedef struct packed {
        logic        ovf;
        logic        udf;
        logic [31:0] rdata;
    } ctl_t;
endpackage

// File: rtl/fwp_fifo.sv
module fwp_fifo #(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned PUSH_BYTES = 4,
    parameter int unsigned PEEK_BYTES = 1,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = AW + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [2:0]              push_n,
    input  logic [8*PUSH_BYTES-1:0] push_data,
    input  logic [2:0]              pop_n,
    output logic [8*PEEK_BYTES-1:0] peek_data,
    output logic [CW-1:0]           level
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t       st_d, st_q;
    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        st_d  = st_q;
        mem_d = mem_q;
        for (int i = 0; i < int'(PUSH_BYTES); i++) begin
            if (i < int'(push_n)) begin
                mem_d[st_q.wr + AW'(i)] = push_data[8*i +: 8];
            end
        end
        st_d.wr  = st_q.wr + AW'(push_n);
        st_d.rd  = st_q.rd + AW'(pop_n);
        st_d.cnt = st_q.cnt + CW'(push_n) - CW'(pop_n);
        if (flush) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end

    for (genvar b = 0; b < int'(PEEK_BYTES); b++) begin : g_peek
        assign peek_data[8*b +: 8] = mem_q[st_q.rd + AW'(b)];
    end

    assign level = st_q.cnt;

    // R5: the level never passes the queue depth
    a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R11: a flush leaves the queue empty at the next edge
    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0);
endmodule

// File: rtl/fwp_flags.sv
module fwp_flags #(
    parameter int unsigned TX_DEPTH = 8,
    parameter int unsigned RX_DEPTH = 16,
    localparam int unsigned TCW = $clog2(TX_DEPTH) + 1,
    localparam int unsigned RCW = $clog2(RX_DEPTH) + 1
) (
    input  logic           wide,
    input  logic [TCW-1:0] tx_level,
    input  logic [RCW-1:0] rx_level,
    output logic           tx_full,
    output logic           tx_avail,
    output logic           rx_empty,
    output logic           rx_avail,
    output logic           eng_tx_valid,
    output logic           eng_rx_ready
);
    logic [TCW-1:0] tx_free;
    logic [TCW-1:0] tx_unit;
    logic [RCW-1:0] rx_unit;
    logic           room_ok;
    logic           data_ok;

    always_comb begin
        tx_unit      = wide ? TCW'(fwp_pkg::WORD_BYTES) : TCW'(1);
        rx_unit      = wide ? RCW'(fwp_pkg::WORD_BYTES) : RCW'(1);
        tx_free      = TCW'(TX_DEPTH) - tx_level;
        room_ok      = tx_free >= tx_unit;
        data_ok      = rx_level >= rx_unit;
        tx_full      = !room_ok;
        tx_avail     = room_ok;
        rx_empty     = !data_ok;
        rx_avail     = data_ok;
        eng_tx_valid = tx_level != '0;
        eng_rx_ready = rx_level < RCW'(RX_DEPTH);
    end
endmodule

// File: rtl/fwp_top.sv
module fwp_top #(
    parameter int unsigned TX_DEPTH = 8,
    parameter int unsigned ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] BYTE_OFS = 4'h0,
    parameter logic [ADDR_W-1:0] WORD_OFS = 4'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              eng_pop,
    output logic [7:0]        eng_tx_byte,
    output logic              eng_tx_valid,
    input  logic              eng_push,
    input  logic [7:0]        eng_rx_byte,
    output logic              eng_rx_ready,
    output logic              tx_full,
    output logic              tx_avail,
    output logic              rx_empty,
    output logic              rx_avail,
    output logic              ovf,
    output logic              udf
);
    import fwp_pkg::*;

    localparam int unsigned RX_DEPTH = 2 * TX_DEPTH;
    localparam int unsigned TCW = $clog2(TX_DEPTH) + 1;
    localparam int unsigned RCW = $clog2(RX_DEPTH) + 1;

    ctl_t           ctl_d, ctl_q;
    logic           live_hit;
    logic [2:0]     unit_n;
    logic [2:0]     tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic [31:0]    tx_push_data;
    logic [31:0]    rx_peek;
    logic [TCW-1:0] tx_level;
    logic [RCW-1:0] rx_level;

    always_comb begin
        live_hit     = wide ? (bus_addr == WORD_OFS) : (bus_addr == BYTE_OFS);
        unit_n       = wide ? CNT_W'(WORD_BYTES) : CNT_W'(1);
        tx_push_data = wide ? bus_wdata : {24'h0, bus_wdata[7:0]};
        tx_push_n    = (bus_wr && live_hit && tx_avail) ? unit_n : '0;
        rx_pop_n     = (bus_rd && live_hit && rx_avail) ? unit_n : '0;
        tx_pop_n     = (eng_pop && eng_tx_valid) ? 3'd1 : 3'd0;
        rx_push_n    = (eng_push && eng_rx_ready) ? 3'd1 : 3'd0;

        ctl_d = ctl_q;
        if (bus_wr && live_hit && !tx_avail) begin
            ctl_d.ovf = 1'b1;
        end
        if (bus_rd) begin
            if (!live_hit) begin
                ctl_d.rdata = '0;
            end else if (!rx_avail) begin
                ctl_d.rdata = '0;
                ctl_d.udf   = 1'b1;
            end else begin
                ctl_d.rdata = wide ? rx_peek : {24'h0, rx_peek[7:0]};
            end
        end
        if (flush) begin
            ctl_d.ovf = 1'b0;
            ctl_d.udf = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    fwp_fifo #(.DEPTH(TX_DEPTH), .PUSH_BYTES(4), .PEEK_BYTES(1)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_n   (tx_push_n),
        .push_data(tx_push_data),
        .pop_n    (tx_pop_n),
        .peek_data(eng_tx_byte),
        .level    (tx_level)
    );

    fwp_fifo #(.DEPTH(RX_DEPTH), .PUSH_BYTES(1), .PEEK_BYTES(4)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .push_n   (rx_push_n),
        .push_data(eng_rx_byte),
        .pop_n    (rx_pop_n),
        .peek_data(rx_peek),
        .level    (rx_level)
    );

    fwp_flags #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_flags (
        .wide        (wide),
        .tx_level    (tx_level),
        .rx_level    (rx_level),
        .tx_full     (tx_full),
        .tx_avail    (tx_avail),
        .rx_empty    (rx_empty),
        .rx_avail    (rx_avail),
        .eng_tx_valid(eng_tx_valid),
        .eng_rx_ready(eng_rx_ready)
    );

    assign bus_rdata = ctl_q.rdata;
    assign ovf       = ctl_q.ovf;
    assign udf       = ctl_q.udf;

    // R8: a write refused for lack of room leaves the transmit level alone
    a_r8_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (bus_wr && live_hit && tx_full && tx_pop_n == '0) |=> $stable(tx_level));

    // R8: the overflow flag only falls after a flush
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf) |-> $past(flush));

    // R9: a starved read yields zero and raises underflow
    a_r9_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (bus_rd && live_hit && rx_empty) |=> (bus_rdata == '0 && udf));

    // R10: a write to the idle window does not touch the transmit queue
    a_r10_idle_window: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (bus_wr && !live_hit && tx_pop_n == '0) |=> $stable(tx_level));
endmodule

// File: tb/sim_fwp_top.sv
module sim_fwp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        wide = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        eng_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_valid;
    logic        eng_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_ready;
    logic        tx_full, tx_avail, rx_empty, rx_avail, ovf, udf;

    int n_run = 0;
    int n_bad = 0;

    localparam logic [3:0] A_BYTE = 4'h0;
    localparam logic [3:0] A_WORD = 4'h4;

    always #5 clk = ~clk;

    fwp_top u0 (
        .clk(clk), .rst_n(rst_n), .flush(flush), .wide(wide),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .eng_pop(eng_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_valid(eng_tx_valid),
        .eng_push(eng_push), .eng_rx_byte(eng_rx_byte), .eng_rx_ready(eng_rx_ready),
        .tx_full(tx_full), .tx_avail(tx_avail), .rx_empty(rx_empty), .rx_avail(rx_avail),
        .ovf(ovf), .udf(udf)
    );

    // op[35:33], wide[32], data or expected value[31:0]
    // ops: 0 byte write, 1 word write, 2 engine pop (check), 3 engine push,
    //      4 byte read (check), 5 word read (check)
    localparam int NV = 14;
    localparam logic [35:0] VECS [NV] = '{
        {3'd0, 1'b0, 32'h11223344},
        {3'd1, 1'b1, 32'hA1B2C3D4},
        {3'd2, 1'b0, 32'h00000044},
        {3'd2, 1'b0, 32'h000000D4},
        {3'd2, 1'b0, 32'h000000C3},
        {3'd2, 1'b0, 32'h000000B2},
        {3'd2, 1'b0, 32'h000000A1},
        {3'd3, 1'b0, 32'h0000005A},
        {3'd3, 1'b0, 32'h00000001},
        {3'd3, 1'b0, 32'h00000002},
        {3'd3, 1'b0, 32'h00000003},
        {3'd4, 1'b0, 32'h0000005A},
        {3'd3, 1'b0, 32'h00000004},
        {3'd5, 1'b1, 32'h04030201}
    };

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick;
        bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        tick;
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic epop(output logic [7:0] b);
        b = eng_tx_byte;
        eng_pop = 1'b1;
        tick;
        eng_pop = 1'b0;
    endtask

    task automatic epush(input logic [7:0] b);
        eng_rx_byte = b; eng_push = 1'b1;
        tick;
        eng_push = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  pb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        check("R12 tx_full", 32'(tx_full), 32'd0);
        check("R12 tx_avail", 32'(tx_avail), 32'd1);
        check("R12 rx_empty", 32'(rx_empty), 32'd1);
        check("R12 rx_avail", 32'(rx_avail), 32'd0);
        check("R12 sticky", {30'd0, ovf, udf}, 32'd0);
        check("R12 rdata", bus_rdata, 32'd0);
        check("R12 engine", {30'd0, eng_tx_valid, eng_rx_ready}, 32'd1);

        // table walk: R1 R2 R3 R4 ordering
        for (int v = 0; v < NV; v++) begin
            logic [2:0]  op;
            logic [31:0] d;
            op   = VECS[v][35:33];
            wide = VECS[v][32];
            d    = VECS[v][31:0];
            case (op)
                3'd0: bwrite(A_BYTE, d);
                3'd1: bwrite(A_WORD, d);
                3'd2: begin epop(pb); check("R1/R2 pop order", 32'(pb), d); end
                3'd3: epush(d[7:0]);
                3'd4: begin bread(A_BYTE, rd); check("R3 byte read", rd, d); end
                default: begin bread(A_WORD, rd); check("R4 word read", rd, d); end
            endcase
        end

        // R6 / R8: transmit flags and overflow
        wide = 1'b1;
        bwrite(A_WORD, 32'h03020100);
        check("R6 wide free4 full", 32'(tx_full), 32'd0);
        check("R6 wide free4 avail", 32'(tx_avail), 32'd1);
        bwrite(A_WORD, 32'h07060504);
        check("R6 wide free0 full", 32'(tx_full), 32'd1);
        bwrite(A_WORD, 32'hDEADBEEF);
        check("R8 ovf set", 32'(ovf), 32'd1);
        epop(pb);
        check("R6 wide free1 full", 32'(tx_full), 32'd1);
        wide = 1'b0; #1;
        check("R6 byte free1 full", 32'(tx_full), 32'd0);
        check("R6 byte free1 avail", 32'(tx_avail), 32'd1);
        // R10: idle-window write ignored
        wide = 1'b1;
        bwrite(A_BYTE, 32'h00000099);
        wide = 1'b0; #1;
        check("R10 idle write kept room", 32'(tx_full), 32'd0);
        bwrite(A_BYTE, 32'h00000055);
        check("R10 room was one byte", 32'(tx_full), 32'd1);
        check("R8 ovf sticky", 32'(ovf), 32'd1);
        for (int k = 1; k < 8; k++) begin
            epop(pb);
            check("R8 dropped word absent", 32'(pb), 32'(k));
        end
        epop(pb);
        check("R10 byte after", 32'(pb), 32'h55);
        check("R8 queue drained", 32'(eng_tx_valid), 32'd0);

        // R11: flush
        bwrite(A_BYTE, 32'h00000077);
        epush(8'h10);
        flush = 1'b1; tick; flush = 1'b0;
        check("R11 tx empty", 32'(eng_tx_valid), 32'd0);
        check("R11 rx empty", 32'(rx_empty), 32'd1);
        check("R11 ovf cleared", 32'(ovf), 32'd0);

        // R7 / R5 / R4 / R9
        wide = 1'b1;
        epush(8'h20); epush(8'h21); epush(8'h22);
        check("R7 wide three empty", 32'(rx_empty), 32'd1);
        check("R7 wide three avail", 32'(rx_avail), 32'd0);
        wide = 1'b0; #1;
        check("R7 byte three empty", 32'(rx_empty), 32'd0);
        check("R7 byte three avail", 32'(rx_avail), 32'd1);
        bread(A_WORD, rd);
        check("R10 idle read zero", rd, 32'd0);
        check("R10 idle read no udf", 32'(udf), 32'd0);
        for (int k = 3; k < 16; k++) begin
            if (k == 15) check("R5 room at 15", 32'(eng_rx_ready), 32'd1);
            epush(8'(32'h20 + k));
        end
        check("R5 full at 16", 32'(eng_rx_ready), 32'd0);
        epush(8'hFF);
        wide = 1'b1;
        for (int w = 0; w < 4; w++) begin
            logic [31:0] e;
            e = {8'(35 + 4*w), 8'(34 + 4*w), 8'(33 + 4*w), 8'(32 + 4*w)};
            bread(A_WORD, rd);
            check("R4/R5 word drain", rd, e);
        end
        check("R5 extra push dropped", 32'(rx_empty), 32'd1);
        wide = 1'b0; #1;
        check("R5 nothing left", 32'(rx_empty), 32'd1);
        bread(A_BYTE, rd);
        check("R9 empty read zero", rd, 32'd0);
        check("R9 udf set", 32'(udf), 32'd1);
        flush = 1'b1; tick; flush = 1'b0;
        check("R11 udf cleared", 32'(udf), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule